// File: doc/BRIEF.md
# Clock Buffer Configuration Register Slave on SMBus

This block is the serial configuration port of a two-output clock buffer. It is a slave-only SMBus target at one fixed 7-bit address, and it holds a small bank of control and identification registers. A host writes a block by sending a starting register offset, a non-zero byte count and then the data bytes. The slave advances through the registers on its own as each byte arrives. To read a block, the host writes the offset, issues a repeated start with the read address, and receives a byte count and then that many register bytes. The number of bytes returned is set by a writable register.

SCL and SDA arrive as plain sampled inputs and pass through a synchronizer before edge detection. The slave pulls SDA low through an open-drain enable only while it sends an acknowledge or a zero read bit. A control register bit chooses who drives the PLL bandwidth-select and PLL-bypass functions: the register bits, or the device pins.

Top module: `clkbuf_smb_regs`

## Requirements
- R1: The slave acknowledges the address byte 0xD4 (write) and 0xD5 (read), which is address 7'b1101010 with the direction bit. Any other address byte is not acknowledged, and the rest of that transaction has no effect on any register.
- R2: In a write, the slave acknowledges the offset, the count and each data byte. It stores data byte k into register offset+k, with the offset wrapping modulo 256.
- R3: A write count of 0 is not acknowledged. The slave then acknowledges nothing, ignores Start conditions and writes no register until a Stop.
- R4: Data bytes beyond the announced write count are not acknowledged and are discarded.
- R5: After 0xD5 the slave sends the value of register 5 as a count byte, then registers offset, offset+1, and so on, as long as the master acknowledges. After the master's not-acknowledge it releases SDA.
- R6: Register 5 resets to 0x06, is read/write, and sets the count byte and the number of data bytes in a block read.
- R7: Register 3 reads 0x00 and register 4 reads 0x06, and neither can be written. Writes to either one, or to offsets 6 and above, are acknowledged and discarded. Reads of offsets 6 and above return 0x00.
- R8: When bit 7 of register 0 is 1, bw_sel_o equals register 0 bit 1 and bypass_o equals register 0 bit 0. When bit 7 is 0, the outputs follow bw_pin_i and bypass_pin_i. Both paths are combinational.
- R9: A Start or Stop in the middle of a transfer aborts it and returns the slave to address matching or idle. Bytes already written are kept.
- R10: After reset, registers 0, 1 and 2 read 0x00 and SDA is released.
- R11: sda_oe_o is asserted only in the cycle after an SCL falling edge has been seen, or while it stays asserted. It is never asserted outside an acknowledge slot or a read data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| bw_pin_i | input | 1 | Bandwidth-select pin |
| bypass_pin_i | input | 1 | PLL-bypass pin |
| bw_sel_o | output | 1 | Effective bandwidth select |
| bypass_o | output | 1 | Effective PLL bypass |

## Verification
A corrupted pointer or phase state appears on the bus within one byte. A wrong acknowledge shows in the ninth bit of the byte that is in flight, and a misplaced pointer shows as a wrong value in the first read-back byte. A wrong register bit in register 0 reaches bw_sel_o and bypass_o as soon as it is written, so the bench checks those outputs after every write and against random pin levels. Lost lock state or a broken abort shows in the next transaction: it is either acknowledged when it should not be, or it reads back altered data.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;
  localparam logic [6:0] SLV_ADDR = 7'h6A;
  localparam int REG_CTRL = 0;
  localparam int REG_CNT  = 5;
  localparam int EN_BIT   = 7;
  localparam int BW_BIT   = 1;
  localparam int BYP_BIT  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT, ST_LOCK
  } st_e;

  typedef enum logic [1:0] {PH_ADDR, PH_OFFS, PH_CNT, PH_DATA} ph_e;

  function automatic logic [7:0] reg_rst(int idx);
    case (idx)
      4:       return 8'h06;
      5:       return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic reg_ro(int idx);
    return (idx == 3) || (idx == 4);
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s   = scl_sh[STAGES-1];
  assign sda_s   = sda_sh[STAGES-1];
  assign sda_o   = sda_s;
  assign start_o = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o  = scl_s & scl_d & ~sda_d & sda_s;
  assign rise_o  = scl_s & ~scl_d;
  assign fall_o  = ~scl_s & scl_d;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smbreg_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int AW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  output logic [7:0]    ctrl_o,
  output logic [7:0]    cnt_o
);
  localparam int IW = $clog2(NUM_REGS);

  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    if (reg_ro(g)) begin : g_ro
      assign q = reg_rst(g);
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            q <= reg_rst(g);
        else if (we_i && waddr_i == AW'(g))     q <= wdata_i;
      end
    end
    assign regs[g] = q;
  end

  assign rdata_o = (raddr_i < AW'(NUM_REGS)) ? regs[raddr_i[IW-1:0]] : 8'h00;
  assign ctrl_o  = regs[REG_CTRL];
  assign cnt_o   = regs[REG_CNT];
endmodule

// File: rtl/smb_proto.sv
module smb_proto
  import smbreg_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [7:0]    rdata_i,
  input  logic [7:0]    cnt_i,
  output logic          sda_oe_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic [AW-1:0] raddr_o
);
  st_e           st_q;
  ph_e           ph_q;
  logic [3:0]    bitc_q;
  logic [7:0]    sh_q, remain_q;
  logic [AW-1:0] ptr_q;
  logic          rd_q, mack_n_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ph_q     <= PH_ADDR;
      bitc_q   <= '0;
      sh_q     <= '0;
      remain_q <= '0;
      ptr_q    <= '0;
      rd_q     <= 1'b0;
      mack_n_q <= 1'b1;
      oe_q     <= 1'b0;
      we_o     <= 1'b0;
      waddr_o  <= '0;
      wdata_o  <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i && st_q != ST_LOCK) begin
        st_q   <= ST_RX;
        ph_q   <= PH_ADDR;
        bitc_q <= '0;
        oe_q   <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (st_q)
          ST_RX: begin
            if (rise_i) begin
              sh_q   <= {sh_q[6:0], sda_i};
              bitc_q <= bitc_q + 4'd1;
            end else if (fall_i && bitc_q == 4'd8) begin
              bitc_q <= '0;
              st_q   <= ST_RX_ACK;
              oe_q   <= 1'b1;
              case (ph_q)
                PH_ADDR: begin
                  if (sh_q[7:1] == SLV_ADDR) begin
                    rd_q <= sh_q[0];
                    ph_q <= PH_OFFS;
                  end else begin
                    st_q <= ST_WAIT;
                    oe_q <= 1'b0;
                  end
                end
                PH_OFFS: begin
                  ptr_q <= AW'(sh_q);
                  ph_q  <= PH_CNT;
                  rd_q  <= 1'b0;
                end
                PH_CNT: begin
                  if (sh_q == 8'h00) begin
                    st_q <= ST_LOCK;
                    oe_q <= 1'b0;
                  end else begin
                    remain_q <= sh_q;
                    ph_q     <= PH_DATA;
                  end
                end
                default: begin
                  if (remain_q == 8'h00) begin
                    st_q <= ST_WAIT;
                    oe_q <= 1'b0;
                  end else begin
                    we_o     <= 1'b1;
                    waddr_o  <= ptr_q;
                    wdata_o  <= sh_q;
                    ptr_q    <= ptr_q + 1'b1;
                    remain_q <= remain_q - 8'd1;
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (fall_i) begin
              if (rd_q) begin
                sh_q <= cnt_i;
                oe_q <= ~cnt_i[7];
                rd_q <= 1'b0;
                st_q <= ST_TX;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (rise_i) begin
              bitc_q <= bitc_q + 4'd1;
            end else if (fall_i) begin
              if (bitc_q == 4'd8) begin
                oe_q   <= 1'b0;
                bitc_q <= '0;
                st_q   <= ST_TX_ACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b0};
                oe_q <= ~sh_q[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (rise_i) begin
              mack_n_q <= sda_i;
            end else if (fall_i) begin
              if (!mack_n_q) begin
                sh_q  <= rdata_i;
                oe_q  <= ~rdata_i[7];
                ptr_q <= ptr_q + 1'b1;
                st_q  <= ST_TX;
              end else begin
                st_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign raddr_o  = ptr_q;
endmodule

// File: rtl/smb_func_sel.sv
module smb_func_sel
  import smbreg_pkg::*;
(
  input  logic [7:0] ctrl_i,
  input  logic       bw_pin_i,
  input  logic       bypass_pin_i,
  output logic       bw_sel_o,
  output logic       bypass_o
);
  always_comb begin
    if (ctrl_i[EN_BIT]) begin
      bw_sel_o = ctrl_i[BW_BIT];
      bypass_o = ctrl_i[BYP_BIT];
    end else begin
      bw_sel_o = bw_pin_i;
      bypass_o = bypass_pin_i;
    end
  end
endmodule

// File: rtl/clkbuf_smb_regs.sv
module clkbuf_smb_regs #(
  parameter int NUM_REGS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic bw_pin_i,
  input  logic bypass_pin_i,
  output logic bw_sel_o,
  output logic bypass_o
);
  localparam int AW = 8;

  logic          sda_s, start_evt, stop_evt, scl_rise, scl_fall;
  logic          reg_we;
  logic [AW-1:0] reg_waddr, reg_raddr;
  logic [7:0]    reg_wdata, reg_rdata, ctrl_q, cnt_q;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_o   (sda_s),
    .start_o (start_evt),
    .stop_o  (stop_evt),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall)
  );

  smb_proto #(.AW(AW)) u_proto (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sda_i    (sda_s),
    .start_i  (start_evt),
    .stop_i   (stop_evt),
    .rise_i   (scl_rise),
    .fall_i   (scl_fall),
    .rdata_i  (reg_rdata),
    .cnt_i    (cnt_q),
    .sda_oe_o (sda_oe_o),
    .we_o     (reg_we),
    .waddr_o  (reg_waddr),
    .wdata_o  (reg_wdata),
    .raddr_o  (reg_raddr)
  );

  smb_regbank #(.NUM_REGS(NUM_REGS), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .waddr_i (reg_waddr),
    .wdata_i (reg_wdata),
    .raddr_i (reg_raddr),
    .rdata_o (reg_rdata),
    .ctrl_o  (ctrl_q),
    .cnt_o   (cnt_q)
  );

  smb_func_sel u_sel (
    .ctrl_i       (ctrl_q),
    .bw_pin_i     (bw_pin_i),
    .bypass_pin_i (bypass_pin_i),
    .bw_sel_o     (bw_sel_o),
    .bypass_o     (bypass_o)
  );
endmodule

// File: rtl/clkbuf_smb_regs_chk.sv
module clkbuf_smb_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_o,
  input logic       scl_fall,
  input logic       scl_rise,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       reg_we,
  input logic [7:0] ctrl_q,
  input logic [7:0] cnt_q,
  input logic       locked
);
  AST_OE_ON_SCL_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall)); // R11

  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_oe_o); // R9

  AST_EVENTS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall})); // R9

  AST_CNT_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_we) |-> $stable(cnt_q)); // R6

  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_we) |-> $stable(ctrl_q)); // R2

  AST_LOCK_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> !reg_we); // R3

  AST_LOCK_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> !sda_oe_o); // R3
endmodule

bind clkbuf_smb_regs clkbuf_smb_regs_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_oe_o  (sda_oe_o),
  .scl_fall  (scl_fall),
  .scl_rise  (scl_rise),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .reg_we    (reg_we),
  .ctrl_q    (ctrl_q),
  .cnt_q     (cnt_q),
  .locked    (u_proto.st_q == smbreg_pkg::ST_LOCK)
);

// File: tb/test_clkbuf_smb_regs.sv
module test_clkbuf_smb_regs;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic bw_pin = 1'b0, byp_pin = 1'b0;
  logic sda_oe, bw_sel, bypass;
  logic sda_bus;
  int   checks = 0, errors = 0;
  logic [7:0] mdl [6];
  logic [7:0] wdat [16];

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  clkbuf_smb_regs i_clkbuf_smb_regs (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_bus),
    .sda_oe_o     (sda_oe),
    .bw_pin_i     (bw_pin),
    .bypass_pin_i (byp_pin),
    .bw_sel_o     (bw_sel),
    .bypass_o     (bypass)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic logic [7:0] exp_reg(int a);
    return (a < 6) ? mdl[a] : 8'h00;
  endfunction

  function automatic bit is_rw(int a);
    return a < 6 && a != 3 && a != 4;
  endfunction

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw(); scl_m = 1'b1; hw(); hw(); scl_m = 1'b0; hw();
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw();
    ack = !sda_bus;
    hw(); scl_m = 1'b0; hw();
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl_m = 1'b1; hw(); b[i] = sda_bus; hw(); scl_m = 1'b0;
    end
    sda_m = !give_ack; hw(); scl_m = 1'b1; hw(); hw(); scl_m = 1'b0; hw();
    sda_m = 1'b1;
  endtask

  task automatic do_write(input int offs, input int cnt, input int nsend, input string req);
    bit a;
    bus_start();
    wr_byte(8'hD4, a);        chk(a, "R1", a, 1);
    wr_byte(8'(offs), a);     chk(a, "R2", a, 1);
    wr_byte(8'(cnt), a);      chk(a == (cnt != 0), (cnt == 0) ? "R3" : "R2", a, cnt != 0);
    for (int i = 0; i < nsend; i++) begin
      bit ea = (cnt != 0) && (i < cnt);
      int ad = (offs + i) & 255;
      wr_byte(wdat[i], a);
      chk(a == ea, req, a, ea);
      if (ea && is_rw(ad)) mdl[ad] = wdat[i];
    end
    bus_stop();
    #1;
    chk(bw_sel == (mdl[0][7] ? mdl[0][1] : bw_pin), "R8", bw_sel, mdl[0][7] ? mdl[0][1] : bw_pin);
    chk(bypass == (mdl[0][7] ? mdl[0][0] : byp_pin), "R8", bypass, mdl[0][7] ? mdl[0][0] : byp_pin);
  endtask

  task automatic do_read(input int offs, input string req);
    bit a;
    logic [7:0] b;
    int n;
    bus_start();
    wr_byte(8'hD4, a);    chk(a, "R1", a, 1);
    wr_byte(8'(offs), a); chk(a, "R5", a, 1);
    bus_start();
    wr_byte(8'hD5, a);    chk(a, "R1", a, 1);
    rd_byte(1'b1, b);     chk(b == mdl[5], "R6", b, mdl[5]);
    n = mdl[5];
    for (int i = 0; i < n; i++) begin
      logic [7:0] e = exp_reg((offs + i) & 255);
      rd_byte(i != n - 1, b);
      chk(b == e, req, b, e);
    end
    chk(sda_oe == 1'b0, "R5", sda_oe, 0);
    bus_stop();
  endtask

  task automatic set_count(input int v);
    wdat[0] = 8'(v);
    do_write(5, 1, 1, "R6");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] b;
    void'($urandom(32'd4242));
    for (int i = 0; i < 6; i++) mdl[i] = 8'h00;
    mdl[4] = 8'h06; mdl[5] = 8'h06;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);
    bw_pin = 1'b1; byp_pin = 1'b0; #1;
    chk(bw_sel == 1'b1 && bypass == 1'b0, "R8", {bw_sel, bypass}, 2'b10);
    bw_pin = 1'b0; byp_pin = 1'b1; #1;
    chk(bw_sel == 1'b0 && bypass == 1'b1, "R8", {bw_sel, bypass}, 2'b01);
    do_read(0, "R10");

    // wrong address: NACK, nothing written
    bus_start();
    wr_byte(8'hA4, a); chk(!a, "R1", a, 0);
    wr_byte(8'h00, a); chk(!a, "R1", a, 0);
    wr_byte(8'h01, a); chk(!a, "R1", a, 0);
    wr_byte(8'hFF, a); chk(!a, "R1", a, 0);
    bus_stop();
    do_read(0, "R1");

    // register control of functions
    wdat[0] = 8'h83;
    do_write(0, 1, 1, "R8");
    bw_pin = 1'b0; byp_pin = 1'b0; #1;
    chk(bw_sel == 1'b1 && bypass == 1'b1, "R8", {bw_sel, bypass}, 2'b11);
    wdat[0] = 8'h81;
    do_write(0, 1, 1, "R8");
    bw_pin = 1'b1; #1;
    chk(bw_sel == 1'b0 && bypass == 1'b1, "R8", {bw_sel, bypass}, 2'b01);
    wdat[0] = 8'h00;
    do_write(0, 1, 1, "R8");

    // zero count: locked until Stop
    bus_start();
    wr_byte(8'hD4, a); chk(a, "R1", a, 1);
    wr_byte(8'h01, a); chk(a, "R2", a, 1);
    wr_byte(8'h00, a); chk(!a, "R3", a, 0);
    wr_byte(8'h55, a); chk(!a, "R3", a, 0);
    bus_start();
    wr_byte(8'hD4, a); chk(!a, "R3", a, 0);
    wr_byte(8'h01, a); chk(!a, "R3", a, 0);
    bus_stop();
    do_read(0, "R3");

    // bytes beyond count
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    do_write(1, 1, 3, "R4");
    do_read(0, "R4");

    // read-only and out-of-bank
    wdat[0] = 8'h5A; wdat[1] = 8'hAA; wdat[2] = 8'hBB;
    do_write(2, 3, 3, "R7");
    wdat[0] = 8'hC3; wdat[1] = 8'h3C;
    do_write(6, 2, 2, "R7");
    do_read(2, "R7");
    do_read(250, "R7");

    // abort by Start after a data byte, then by Start and Stop mid-byte
    bus_start();
    wr_byte(8'hD4, a); wr_byte(8'h00, a); wr_byte(8'h03, a);
    wr_byte(8'h01, a); chk(a, "R9", a, 1);
    mdl[0] = 8'h01;
    send_bits(8'hF0, 4);
    bus_start();
    wr_byte(8'hD4, a); chk(a, "R9", a, 1);
    wr_byte(8'h01, a); wr_byte(8'h01, a);
    wr_byte(8'h77, a); chk(a, "R9", a, 1);
    mdl[1] = 8'h77;
    send_bits(8'h00, 3);
    bus_stop();
    do_read(0, "R9");

    // master NACK after count byte releases SDA
    bus_start();
    wr_byte(8'hD5, a); chk(a, "R5", a, 1);
    rd_byte(1'b0, b);  chk(b == mdl[5], "R5", b, mdl[5]);
    chk(sda_oe == 1'b0, "R5", sda_oe, 0);
    bus_stop();

    // count register controls read length
    set_count(2);
    do_read(4, "R6");
    set_count(1);
    do_read(0, "R6");

    // constrained random traffic
    for (int it = 0; it < 28; it++) begin
      int offs = $urandom_range(0, 7);
      int cnt  = $urandom_range(1, 4);
      bw_pin  = 1'($urandom_range(0, 1));
      byp_pin = 1'($urandom_range(0, 1));
      for (int i = 0; i < cnt; i++)
        wdat[i] = (offs + i == 5) ? 8'($urandom_range(1, 5)) : 8'($urandom_range(0, 255));
      do_write(offs, cnt, cnt, "R2");
      if (it % 3 == 2) do_read($urandom_range(0, 7), "R5");
    end
    do_read(0, "R2");

    summary();
    $finish;
  end
endmodule